// File: doc/BRIEF.md
# Timing-Fault Pipeline Recovery Controller

This block controls recovery in a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) whose stage registers can detect late-arriving data. The fetch, decode and execute stages are the front stages, indexed 0, 1 and 2 in that order. Each front stage reports a fault flag, a valid bit and the PC of the instruction it holds. When a valid instruction faults, the controller turns that stage's outgoing instruction into a bubble in the same cycle. A recovery token carrying the faulting PC then moves forward one stage per clock, using only neighbour-to-neighbour hand-off.

The token reaches the memory stage, the last stage before commit. There the controller flushes every front stage in a single cycle and redirects fetch to the faulting PC, so that the faulting instruction and every younger one is fetched again. The memory stage is never flushed: older instructions keep draining to writeback. Commit goes through a stabilizing register, which holds back the bubble that carries the token. While a recovery is in flight, further fault reports are ignored. A wrapping event counter lets an external error-rate monitor follow how often recovery happens.

Top module: `rcv_recovery_ctrl`

## Requirements
- R1: While reset is asserted and just after its release, bubble_o, flush_o, redirect_o, restart_pc_o, commit_o and rec_count_o are all zero.
- R2: When no recovery is in flight and front stage s (0 = fetch, 1 = decode, 2 = execute) reports an error with its valid bit set, bit s of bubble_o is 1 in the same cycle.
- R3: When several valid front stages report errors in one cycle, only the highest-index (oldest) one is bubbled, and its PC becomes the restart PC.
- R4: An error flag whose stage valid bit is 0 has no effect: there is no bubble, no redirect and no count change.
- R5: After an accepted error at stage s, redirect_o is high for exactly one cycle, N_FRONT − s cycles later. In that cycle flush_o has every bit set and restart_pc_o equals the PC that stage s reported. Outside redirect cycles, flush_o and restart_pc_o are zero.
- R6: In every cycle that is not a redirect cycle, commit_o in the next cycle equals mem_valid_i, so older instructions drain while a recovery is in flight.
- R7: From the cycle after an error is accepted up to and including its redirect cycle, error reports cause no bubble and start no further recovery.
- R8: In the cycle after a redirect, commit_o is 0 whatever mem_valid_i was, because the token-bearing bubble is never committed.
- R9: rec_count_o rises by one in the cycle after each redirect and wraps modulo 2^CNTW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stg_valid_i | input | N_FRONT | Valid bit per front stage, bit 0 = fetch |
| stg_err_i | input | N_FRONT | Timing-error flag per front stage register |
| stg_pc_i | input | N_FRONT*PCW | PC per front stage, stage s at bits [s*PCW +: PCW] |
| mem_valid_i | input | 1 | Valid bit of the instruction leaving the memory stage |
| bubble_o | output | N_FRONT | Turn this stage's outgoing instruction into a bubble |
| flush_o | output | N_FRONT | Flush the front stages |
| redirect_o | output | 1 | Redirect fetch to restart_pc_o |
| restart_pc_o | output | PCW | PC at which fetching restarts |
| commit_o | output | 1 | Stabilized writeback commit enable |
| rec_count_o | output | CNTW | Wrapping count of completed recoveries |

## Verification
The bound checker checks on every cycle that at most one bubble is raised and that only on a valid faulting stage. It also checks that an execute-stage bubble produces a redirect with that stage's PC in the next cycle, that a redirect never repeats or coexists with a new bubble, that commit follows the memory valid bit or is held back after a redirect, and that the counter steps once per redirect. Only the bench scenarios can show the longer behaviours. These are the multi-cycle token travel from fetch and decode, how long faults are ignored across a whole recovery, the choice of the oldest stage among simultaneous faults, and the counter wrapping after many recoveries.

// File: rtl/rcv_pkg.sv
package rcv_pkg;
   localparam int unsigned RCV_MAX_FRONT = 8;
   localparam int unsigned RCV_IDXW      = 4;
   typedef logic [RCV_IDXW-1:0] stg_idx_t;
endpackage

// File: rtl/rcv_fault_pick.sv
module rcv_fault_pick
   import rcv_pkg::*;
#(
   parameter int unsigned N_FRONT = 3
) (
   input  logic [N_FRONT-1:0] valid_i,
   input  logic [N_FRONT-1:0] err_i,
   output logic               any_o,
   output stg_idx_t           idx_o,
   output logic [N_FRONT-1:0] onehot_o
);
   logic [N_FRONT-1:0] hits;
   assign hits  = valid_i & err_i;
   assign any_o = |hits;

   // The oldest stage has the highest index: a hit wins if no higher hit exists.
   for (genvar s = 0; s < N_FRONT; s++) begin : g_sel
      if (s == N_FRONT - 1) begin : g_top
         assign onehot_o[s] = hits[s];
      end else begin : g_low
         assign onehot_o[s] = hits[s] & ~(|hits[N_FRONT-1:s+1]);
      end
   end

   always_comb begin
      idx_o = '0;
      for (int s = 0; s < N_FRONT; s++) begin
         if (onehot_o[s]) idx_o = stg_idx_t'(s);
      end
   end
endmodule

// File: rtl/rcv_token_pipe.sv
module rcv_token_pipe
   import rcv_pkg::*;
#(
   parameter int unsigned N_FRONT = 3,
   parameter int unsigned PCW     = 32
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           load_i,
   input  stg_idx_t       load_idx_i,
   input  logic [PCW-1:0] load_pc_i,
   output logic           busy_o,
   output logic           at_end_o,
   output logic [PCW-1:0] end_pc_o
);
   // Slot k holds a token that sits one stage past front stage k;
   // slot N_FRONT-1 is the memory stage, where the flush controller acts.
   logic [N_FRONT-1:0]          v_q;
   logic [N_FRONT-1:0][PCW-1:0] pc_q;

   for (genvar k = 0; k < N_FRONT; k++) begin : g_slot
      logic           hit_load;
      logic           v_d;
      logic [PCW-1:0] pc_d;
      assign hit_load = load_i && (load_idx_i == stg_idx_t'(k));
      if (k == 0) begin : g_head
         assign v_d  = hit_load;
         assign pc_d = load_pc_i;
      end else begin : g_body
         assign v_d  = v_q[k-1] | hit_load;
         assign pc_d = hit_load ? load_pc_i : pc_q[k-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q[k]  <= 1'b0;
            pc_q[k] <= '0;
         end else begin
            v_q[k]  <= v_d;
            pc_q[k] <= v_d ? pc_d : '0;
         end
      end
   end

   assign busy_o   = |v_q;
   assign at_end_o = v_q[N_FRONT-1];
   assign end_pc_o = pc_q[N_FRONT-1];
endmodule

// File: rtl/rcv_event_ctr.sv
module rcv_event_ctr #(
   parameter int unsigned CNTW = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_i,
   output logic [CNTW-1:0] count_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count_o <= '0;
      else if (inc_i) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/rcv_recovery_ctrl.sv
module rcv_recovery_ctrl
   import rcv_pkg::*;
#(
   parameter int unsigned N_FRONT = 3,
   parameter int unsigned PCW     = 32,
   parameter int unsigned CNTW    = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_FRONT-1:0]     stg_valid_i,
   input  logic [N_FRONT-1:0]     stg_err_i,
   input  logic [N_FRONT*PCW-1:0] stg_pc_i,
   input  logic                   mem_valid_i,
   output logic [N_FRONT-1:0]     bubble_o,
   output logic [N_FRONT-1:0]     flush_o,
   output logic                   redirect_o,
   output logic [PCW-1:0]         restart_pc_o,
   output logic                   commit_o,
   output logic [CNTW-1:0]        rec_count_o
);
   if (N_FRONT < 1 || N_FRONT > RCV_MAX_FRONT) begin : g_bad_front
      $error("rcv_recovery_ctrl: N_FRONT out of range");
   end
   if (PCW < 2) begin : g_bad_pcw
      $error("rcv_recovery_ctrl: PCW too small");
   end
   if (CNTW < 1) begin : g_bad_cntw
      $error("rcv_recovery_ctrl: CNTW must be at least 1");
   end

   logic               any_hit;
   stg_idx_t           pick_idx;
   logic [N_FRONT-1:0] pick_oh;
   logic               busy;
   logic               at_end;
   logic [PCW-1:0]     end_pc;
   logic               accept;
   logic [PCW-1:0]     load_pc;
   logic               commit_q;

   rcv_fault_pick #(.N_FRONT(N_FRONT)) u_pick (
      .valid_i  (stg_valid_i),
      .err_i    (stg_err_i),
      .any_o    (any_hit),
      .idx_o    (pick_idx),
      .onehot_o (pick_oh)
   );

   assign accept  = any_hit & ~busy;
   assign load_pc = stg_pc_i[pick_idx*PCW +: PCW];

   rcv_token_pipe #(.N_FRONT(N_FRONT), .PCW(PCW)) u_tok (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_idx_i (pick_idx),
      .load_pc_i  (load_pc),
      .busy_o     (busy),
      .at_end_o   (at_end),
      .end_pc_o   (end_pc)
   );

   rcv_event_ctr #(.CNTW(CNTW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (at_end),
      .count_o (rec_count_o)
   );

   // Stabilizer in front of the commit point: the token bubble never commits.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) commit_q <= 1'b0;
      else        commit_q <= mem_valid_i & ~at_end;
   end

   assign bubble_o     = accept ? pick_oh : '0;
   assign flush_o      = {N_FRONT{at_end}};
   assign redirect_o   = at_end;
   assign restart_pc_o = at_end ? end_pc : '0;
   assign commit_o     = commit_q;
endmodule

// File: rtl/rcv_recovery_chk.sv
module rcv_recovery_chk #(
   parameter int unsigned N_FRONT = 3,
   parameter int unsigned PCW     = 32,
   parameter int unsigned CNTW    = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [N_FRONT-1:0]     stg_valid_i,
   input logic [N_FRONT-1:0]     stg_err_i,
   input logic [N_FRONT*PCW-1:0] stg_pc_i,
   input logic                   mem_valid_i,
   input logic [N_FRONT-1:0]     bubble_o,
   input logic [N_FRONT-1:0]     flush_o,
   input logic                   redirect_o,
   input logic [PCW-1:0]         restart_pc_o,
   input logic                   commit_o,
   input logic [CNTW-1:0]        rec_count_o
);
   AST_BUBBLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bubble_o)); // R3
   AST_BUBBLE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (bubble_o & ~(stg_valid_i & stg_err_i)) == '0); // R4
   AST_EX_FAULT_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o[N_FRONT-1] |=> (redirect_o && flush_o == {N_FRONT{1'b1}})); // R5
   AST_EX_RESTART_PC: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o[N_FRONT-1] |=> restart_pc_o == $past(stg_pc_i[(N_FRONT-1)*PCW +: PCW])); // R5
   AST_REDIRECT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !redirect_o); // R5
   AST_COMMIT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_o |=> commit_o == $past(mem_valid_i)); // R6
   AST_QUIET_ON_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |-> bubble_o == '0); // R7
   AST_COMMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> !commit_o); // R8
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      redirect_o |=> rec_count_o == $past(rec_count_o) + 1'b1); // R9
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !redirect_o |=> $stable(rec_count_o)); // R9
endmodule

bind rcv_recovery_ctrl rcv_recovery_chk #(.N_FRONT(N_FRONT), .PCW(PCW), .CNTW(CNTW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .stg_valid_i  (stg_valid_i),
   .stg_err_i    (stg_err_i),
   .stg_pc_i     (stg_pc_i),
   .mem_valid_i  (mem_valid_i),
   .bubble_o     (bubble_o),
   .flush_o      (flush_o),
   .redirect_o   (redirect_o),
   .restart_pc_o (restart_pc_o),
   .commit_o     (commit_o),
   .rec_count_o  (rec_count_o)
);

// File: tb/tb_rcv_recovery_ctrl.sv
`timescale 1ns/1ps
module tb_rcv_recovery_ctrl;
   localparam int NF   = 3;
   localparam int PCW  = 32;
   localparam int CNTW = 4;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [NF-1:0]     stg_valid = '0;
   logic [NF-1:0]     stg_err = '0;
   logic [NF*PCW-1:0] stg_pc = '0;
   logic              mem_valid = 1'b0;
   logic [NF-1:0]     bubble, flush;
   logic              redirect, commit;
   logic [PCW-1:0]    restart_pc;
   logic [CNTW-1:0]   rec_count;

   rcv_recovery_ctrl #(.N_FRONT(NF), .PCW(PCW), .CNTW(CNTW)) dut (
      .clk(clk), .rst_n(rst_n), .stg_valid_i(stg_valid), .stg_err_i(stg_err),
      .stg_pc_i(stg_pc), .mem_valid_i(mem_valid), .bubble_o(bubble),
      .flush_o(flush), .redirect_o(redirect), .restart_pc_o(restart_pc),
      .commit_o(commit), .rec_count_o(rec_count)
   );

   int checks = 0;
   int errors = 0;
   int cyc    = 0;

   // Reference model state: token position (0 = none, NF = memory stage).
   int             m_pos    = 0;
   logic [PCW-1:0] m_pc     = '0;
   int             m_cnt    = 0;
   logic           m_commit = 1'b0;

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [NF-1:0] v, input logic [NF-1:0] e,
                       input logic mv, input string tag);
      int                pick;
      logic [NF-1:0]     exp_bub;
      logic [NF*PCW-1:0] pcs;
      logic              redir;
      @(negedge clk);
      for (int s = 0; s < NF; s++) pcs[s*PCW +: PCW] = PCW'(32'h4000_0000 + cyc * 64 + s * 4);
      stg_valid = v;
      stg_err   = e;
      stg_pc    = pcs;
      mem_valid = mv;
      #1;
      pick = -1;
      if (m_pos == 0) begin
         for (int s = 0; s < NF; s++) if (v[s] && e[s]) pick = s;
      end
      exp_bub = (pick >= 0) ? (NF'(1) << pick) : '0;
      redir   = (m_pos == NF);
      chk(tag, "bubble",     64'(bubble),     64'(exp_bub));
      chk(tag, "flush",      64'(flush),      redir ? 64'((1 << NF) - 1) : 64'd0);
      chk(tag, "redirect",   64'(redirect),   64'(redir));
      chk(tag, "restart_pc", 64'(restart_pc), redir ? 64'(m_pc) : 64'd0);
      chk(tag, "commit",     64'(commit),     64'(m_commit));
      chk(tag, "rec_count",  64'(rec_count),  64'(m_cnt % (1 << CNTW)));
      @(posedge clk);
      cyc++;
      if (!rst_n) begin
         m_pos = 0; m_pc = '0; m_cnt = 0; m_commit = 1'b0;
      end else begin
         m_commit = mv && !redir;
         if (redir) begin
            m_cnt++;
            m_pos = 0;
         end else if (m_pos != 0) begin
            m_pos++;
         end else if (pick >= 0) begin
            m_pos = pick + 1;
            m_pc  = pcs[pick*PCW +: PCW];
         end
      end
   endtask

   initial begin
      step(3'b000, 3'b000, 1'b0, "R1");
      step(3'b000, 3'b000, 1'b0, "R1");
      @(negedge clk);
      rst_n = 1'b1;
      step(3'b111, 3'b000, 1'b1, "R1");
      // Drain pattern with no faults
      step(3'b111, 3'b000, 1'b0, "R6");
      step(3'b011, 3'b000, 1'b1, "R6");
      // Execute-stage fault, redirect next cycle; commit held after it
      step(3'b111, 3'b100, 1'b1, "R2");
      step(3'b111, 3'b000, 1'b1, "R5");
      step(3'b111, 3'b000, 1'b1, "R8");
      step(3'b111, 3'b000, 1'b1, "R6");
      // Fetch-stage fault: three cycles of travel, new faults ignored
      step(3'b111, 3'b001, 1'b1, "R2");
      step(3'b111, 3'b111, 1'b1, "R7");
      step(3'b111, 3'b010, 1'b0, "R7");
      step(3'b111, 3'b100, 1'b1, "R7");
      step(3'b111, 3'b000, 1'b1, "R8");
      // Decode-stage fault
      step(3'b111, 3'b010, 1'b0, "R2");
      step(3'b111, 3'b000, 1'b1, "R5");
      step(3'b111, 3'b001, 1'b1, "R7");
      step(3'b111, 3'b000, 1'b1, "R5");
      // Simultaneous faults: oldest wins
      step(3'b111, 3'b011, 1'b1, "R3");
      step(3'b111, 3'b000, 1'b1, "R3");
      step(3'b111, 3'b000, 1'b1, "R3");
      step(3'b111, 3'b111, 1'b1, "R3");
      step(3'b111, 3'b000, 1'b1, "R3");
      step(3'b111, 3'b000, 1'b1, "R3");
      // Faults on invalid stages
      step(3'b000, 3'b111, 1'b1, "R4");
      step(3'b011, 3'b100, 1'b1, "R4");
      step(3'b110, 3'b001, 1'b0, "R4");
      step(3'b000, 3'b000, 1'b0, "R4");
      // Back-to-back recoveries until the counter wraps
      for (int i = 0; i < 20; i++) begin
         step(3'b111, 3'b100, 1'b1, "R9");
         step(3'b111, 3'b000, 1'b1, "R9");
      end
      step(3'b000, 3'b000, 1'b0, "R9");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule